// File: doc/BRIEF.md
# Microwire Frame Master

This block is the master end of a Microwire serial link. It divides the system clock into a free-running serial clock, and for every accepted request it runs one frame on the wire. The frame begins with an 8-bit command shifted out to the slave. One idle turnaround period follows. The block then captures a reply from the slave whose length is set per request, anywhere from 4 to 16 bits. The active-low select line is lowered and raised on serial-clock falling edges. Its placement gives the slave at least two serial-clock periods of setup before the first command bit is sampled, and keeps the line high for at least one full period between frames.

Requests enter through a valid/ready handshake into a single holding slot. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` drops while the slot holds a request that has not yet started, and the requester must then hold its request steady. The slot is emptied at the falling serial-clock edge where the held request starts its frame, so one request can wait behind a running frame. That waiting request begins exactly one serial-clock period after the running frame releases the select line. The reply leaves through `rsp_valid`/`rsp_data`. That output has no back-pressure: `rsp_valid` is a one-cycle pulse, and `rsp_data` keeps its value until the next reply.

Top module: `mw_master`

## Requirements
- R1: `ser_clk` is low out of reset and then toggles without stopping, one full period every CLK_DIV system clocks (CLK_DIV even, at least 2), whether or not a frame is running.
- R2: While reset is held and just after it, `sel_n` is 1, `ser_out` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R3: A request is accepted when `req_valid` and `req_ready` are high at the same edge. `req_ready` is 0 while an accepted request waits behind a running frame, and requests run in the order they were accepted.
- R4: `sel_n` changes only on a `ser_clk` falling edge. When `sel_n` falls, the first command bit is sampled on the third `ser_clk` rising edge after the fall, 2.5 serial periods later.
- R5: The 8-bit command goes out on `ser_out` MSB first, one bit for each of rising edges 3 to 10 after `sel_n` falls. `ser_out` changes only on `ser_clk` falling edges and is 0 outside the command bits.
- R6: Rising edge 11 after `sel_n` falls is a turnaround edge, and the value on `ser_in` at that edge has no effect on the reply.
- R7: The reply length L is `req_len` limited to the range 4 to 16 (0 to 3 give 4, 17 to 31 give 16). `ser_in` is sampled MSB first on rising edges 12 to 11+L.
- R8: `rsp_valid` is high for exactly one clock, in the cycle after the edge that samples the last reply bit, while `sel_n` is still 0. `rsp_data` then holds the L reply bits right-justified, with the upper 16-L bits 0.
- R9: `sel_n` rises on the first `ser_clk` falling edge after the last reply bit, with no rising edge between. It stays high for at least one serial period. A waiting request lowers it again exactly one serial period after it rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Holding slot can take a request |
| req_cmd | input | 8 | Command byte for the frame |
| req_len | input | 5 | Reply length in bits, limited to 4..16 |
| rsp_valid | output | 1 | One-cycle pulse: reply available |
| rsp_data | output | 16 | Right-justified, zero-extended reply |
| ser_clk | output | 1 | Free-running serial clock |
| sel_n | output | 1 | Active-low slave select |
| ser_out | output | 1 | Serial data to the slave |
| ser_in | input | 1 | Serial data from the slave |

## Verification
The bench builds the block with CLK_DIV set to 4 and the default 8-bit command and 4 to 16 bit reply range. With CLK_DIV at 4, each half of a serial period spans two system clocks. The slave model can then change `ser_in` in the middle of a low half, and every edge distance (setup, release, gap, period) is a whole multiple of 10 ns that can be compared exactly. The 5-bit length field reaches 0 and 31, so both ends of the length limit are exercised. A junk 1 on the turnaround edge and back-to-back requests cover the ignored edge and the one-period gap.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_CMD,
    ST_TURN,
    ST_RESP,
    ST_TAIL
  } mw_state_e;
endpackage

// File: rtl/mw_sk_gen.sv
module mw_sk_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic ser_clk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int HALF = CLK_DIV / 2;
  localparam int HC_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HC_W-1:0] hc;
  logic            sk_q;
  logic            wrap;

  assign wrap      = (hc == HC_W'(HALF - 1));
  assign rise_tick = wrap && !sk_q;
  assign fall_tick = wrap && sk_q;
  assign ser_clk   = sk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc   <= '0;
      sk_q <= 1'b0;
    end else if (wrap) begin
      hc   <= '0;
      sk_q <= ~sk_q;
    end else begin
      hc <= hc + 1'b1;
    end
  end
endmodule

// File: rtl/mw_req_slot.sv
module mw_req_slot #(
  parameter int CMD_W   = 8,
  parameter int RSP_MIN = 4,
  parameter int RSP_MAX = 16,
  parameter int LEN_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CMD_W-1:0] req_cmd,
  input  logic [LEN_W-1:0] req_len,
  input  logic             take,
  output logic             full,
  output logic [CMD_W-1:0] slot_cmd,
  output logic [LEN_W-1:0] slot_len
);
  logic [LEN_W-1:0] len_lim;

  always_comb begin
    if (req_len < LEN_W'(RSP_MIN))      len_lim = LEN_W'(RSP_MIN);
    else if (req_len > LEN_W'(RSP_MAX)) len_lim = LEN_W'(RSP_MAX);
    else                                len_lim = req_len;
  end

  assign req_ready = !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full     <= 1'b0;
      slot_cmd <= '0;
      slot_len <= LEN_W'(RSP_MIN);
    end else if (req_valid && req_ready) begin
      full     <= 1'b1;
      slot_cmd <= req_cmd;
      slot_len <= len_lim;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/mw_frame_fsm.sv
module mw_frame_fsm
  import mw_pkg::*;
#(
  parameter int CMD_W    = 8,
  parameter int RSP_MAX  = 16,
  parameter int LEN_W    = 5,
  parameter int LEAD_PER = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise_tick,
  input  logic               fall_tick,
  input  logic               slot_full,
  input  logic [CMD_W-1:0]   slot_cmd,
  input  logic [LEN_W-1:0]   slot_len,
  output logic               take,
  output logic               sel_n,
  output logic               ser_out,
  input  logic               ser_in,
  output logic               rsp_valid,
  output logic [RSP_MAX-1:0] rsp_data
);
  localparam int MAXC = (CMD_W > RSP_MAX) ? ((CMD_W > LEAD_PER) ? CMD_W : LEAD_PER)
                                          : ((RSP_MAX > LEAD_PER) ? RSP_MAX : LEAD_PER);
  localparam int CW   = $clog2(MAXC + 1);

  mw_state_e          state;
  logic [CW-1:0]      cnt;
  logic [CMD_W-1:0]   cmd_sh;
  logic [LEN_W-1:0]   len_q;
  logic [RSP_MAX-2:0] rx;

  assign take = (state == ST_IDLE) && fall_tick && slot_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      cmd_sh    <= '0;
      len_q     <= '0;
      rx        <= '0;
      sel_n     <= 1'b1;
      ser_out   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (take) begin
          sel_n  <= 1'b0;
          state  <= ST_LEAD;
          cnt    <= '0;
          cmd_sh <= slot_cmd;
          len_q  <= slot_len;
        end
        ST_LEAD: if (fall_tick) begin
          if (cnt == CW'(LEAD_PER - 1)) begin
            state   <= ST_CMD;
            ser_out <= cmd_sh[CMD_W-1];
            cmd_sh  <= cmd_sh << 1;
            cnt     <= CW'(CMD_W - 1);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CMD: if (fall_tick) begin
          if (cnt == '0) begin
            state   <= ST_TURN;
            ser_out <= 1'b0;
          end else begin
            ser_out <= cmd_sh[CMD_W-1];
            cmd_sh  <= cmd_sh << 1;
            cnt     <= cnt - 1'b1;
          end
        end
        ST_TURN: if (fall_tick) begin
          state <= ST_RESP;
          cnt   <= CW'(len_q) - 1'b1;
          rx    <= '0;
        end
        ST_RESP: begin
          if (rise_tick) begin
            rx <= {rx[RSP_MAX-3:0], ser_in};
            if (cnt == '0) begin
              rsp_valid <= 1'b1;
              rsp_data  <= {rx, ser_in};
              state     <= ST_TAIL;
            end
          end else if (fall_tick) begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_TAIL: if (fall_tick) begin
          sel_n <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_master.sv
module mw_master #(
  parameter int CLK_DIV  = 4,
  parameter int CMD_W    = 8,
  parameter int RSP_MIN  = 4,
  parameter int RSP_MAX  = 16,
  parameter int LEAD_PER = 2,
  localparam int LEN_W   = $clog2(RSP_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [CMD_W-1:0]   req_cmd,
  input  logic [LEN_W-1:0]   req_len,
  output logic               rsp_valid,
  output logic [RSP_MAX-1:0] rsp_data,
  output logic               ser_clk,
  output logic               sel_n,
  output logic               ser_out,
  input  logic               ser_in
);
  logic             rise_tick;
  logic             fall_tick;
  logic             take;
  logic             full;
  logic [CMD_W-1:0] slot_cmd;
  logic [LEN_W-1:0] slot_len;

  mw_sk_gen #(.CLK_DIV(CLK_DIV)) u_sk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_clk  (ser_clk),
    .rise_tick(rise_tick),
    .fall_tick(fall_tick)
  );

  mw_req_slot #(
    .CMD_W  (CMD_W),
    .RSP_MIN(RSP_MIN),
    .RSP_MAX(RSP_MAX),
    .LEN_W  (LEN_W)
  ) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_cmd  (req_cmd),
    .req_len  (req_len),
    .take     (take),
    .full     (full),
    .slot_cmd (slot_cmd),
    .slot_len (slot_len)
  );

  mw_frame_fsm #(
    .CMD_W   (CMD_W),
    .RSP_MAX (RSP_MAX),
    .LEN_W   (LEN_W),
    .LEAD_PER(LEAD_PER)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_tick(rise_tick),
    .fall_tick(fall_tick),
    .slot_full(full),
    .slot_cmd (slot_cmd),
    .slot_len (slot_len),
    .take     (take),
    .sel_n    (sel_n),
    .ser_out  (ser_out),
    .ser_in   (ser_in),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data)
  );
endmodule

// File: rtl/mw_master_chk.sv
module mw_master_chk #(
  parameter int CLK_DIV = 4
) (
  input logic clk,
  input logic rst_n,
  input logic ser_clk,
  input logic sel_n,
  input logic ser_out,
  input logic rsp_valid
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            hi_cnt <= '0;
    else if (!sel_n)       hi_cnt <= '0;
    else if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
  end

  // R4
  sel_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_n) |-> $fell(ser_clk));

  // R5
  out_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_out) |-> $fell(ser_clk));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8
  done_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !sel_n);

  // R9
  sel_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_n) |-> (hi_cnt >= 16'(CLK_DIV)));
endmodule

bind mw_master mw_master_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ser_clk  (ser_clk),
  .sel_n    (sel_n),
  .ser_out  (ser_out),
  .rsp_valid(rsp_valid)
);

// File: tb/sim_mw_master.sv
`timescale 1ns/100ps
module sim_mw_master;
  localparam int  DIV  = 4;
  localparam real TCLK = 5.0;
  localparam real TSK  = DIV * TCLK;

  typedef struct {
    logic [7:0]  cmd;
    int          len;
    logic [15:0] resp;
    bit          tight;
  } item_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [7:0]  req_cmd = 0;
  logic [4:0]  req_len = 0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        ser_clk, sel_n, ser_out;
  logic        ser_in = 1;

  int errors = 0, checks = 0, outstanding = 0;
  item_t q[$];
  item_t cur;
  int    k = 0;
  logic [7:0] cap;
  real   t_fall = 0, t_rel = -1000, t_lastrise = 0, t_prevrise = -1;
  bit    frame_seen = 0;

  mw_master #(.CLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_len(req_len), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ser_clk(ser_clk), .sel_n(sel_n), .ser_out(ser_out), .ser_in(ser_in)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit near(input real a, input real b);
    return (a - b < 0.1) && (b - a < 0.1);
  endfunction

  function automatic int lim(input int l);
    return (l < 4) ? 4 : ((l > 16) ? 16 : l);
  endfunction

  task automatic send(input logic [7:0] c, input int l, input logic [15:0] r, input bit tight);
    item_t it;
    @(negedge clk);
    req_valid = 1; req_cmd = c; req_len = 5'(l);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    it.cmd = c; it.len = lim(l);
    it.resp = r & 16'((32'd1 << it.len) - 1);
    it.tight = tight;
    q.push_back(it);
    outstanding++;
    @(negedge clk);
    req_valid = 0;
  endtask

  // slave model: frame start
  always @(negedge sel_n) begin
    if (q.size() == 0) chk(0, "R3 frame without request", 0, 1);
    else cur = q.pop_front();
    k = 0; cap = 0;
    if (frame_seen) begin
      chk(($realtime - t_rel) > TSK - 0.1, "R9 gap", longint'($realtime - t_rel), longint'(TSK));
      if (cur.tight)
        chk(near($realtime - t_rel, TSK), "R9 back-to-back gap", longint'($realtime - t_rel), longint'(TSK));
    end
    frame_seen = 1;
    t_fall = $realtime;
  end

  always @(posedge sel_n) begin
    if (frame_seen) begin
      t_rel = $realtime;
      chk(k == 11 + cur.len, "R9 release edge count", k, 11 + cur.len);
      chk(near($realtime - t_lastrise, TSK / 2), "R9 release half period after last sample",
          longint'($realtime - t_lastrise), longint'(TSK / 2));
    end
  end

  // slave model: rising edges
  always @(posedge ser_clk) begin
    if (t_prevrise >= 0)
      chk(near($realtime - t_prevrise, TSK), "R1 period", longint'($realtime - t_prevrise), longint'(TSK));
    t_prevrise = $realtime;
    if (!sel_n) begin
      k++;
      t_lastrise = $realtime;
      if (k == 3)
        chk(near($realtime - t_fall, 2.5 * TSK), "R4 setup", longint'($realtime - t_fall), longint'(2.5 * TSK));
      if (k >= 3 && k <= 10) cap = {cap[6:0], ser_out};
      if (k == 11) chk(ser_out == 0, "R5 idle out at turnaround", ser_out, 0);
    end
  end

  // slave model: reply bits, driven in the low half (junk 1 elsewhere, incl. turnaround R6)
  always @(negedge clk) begin
    if (!sel_n && !ser_clk) begin
      int nxt;
      nxt = k + 1;
      if (nxt >= 12 && nxt <= 11 + cur.len) ser_in = cur.resp[cur.len - 1 - (nxt - 12)];
      else ser_in = 1'b1;
    end else if (sel_n) ser_in = 1'b1;
  end

  // monitor: scoreboard compare
  bit pulse_seen = 0;
  always @(negedge clk) begin
    if (pulse_seen) begin
      chk(rsp_valid == 0, "R8 one-cycle pulse", rsp_valid, 0);
      pulse_seen = 0;
    end else if (rst_n && rsp_valid) begin
      pulse_seen = 1;
      chk(rsp_data == cur.resp, "R8 reply data", rsp_data, cur.resp);
      chk(k == 11 + cur.len, "R7 reply length", k, 11 + cur.len);
      chk(cap == cur.cmd, "R5 command bits", cap, cur.cmd);
      chk(sel_n == 0, "R8 select low at done", sel_n, 0);
      outstanding--;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(sel_n == 1, "R2 reset sel_n", sel_n, 1);
    chk(ser_out == 0, "R2 reset ser_out", ser_out, 0);
    chk(rsp_valid == 0, "R2 reset rsp_valid", rsp_valid, 0);
    chk(req_ready == 1, "R2 reset req_ready", req_ready, 1);
    chk(ser_clk == 0, "R1 reset ser_clk low", ser_clk, 0);
    rst_n = 1;
    @(negedge clk);
    chk(sel_n == 1 && req_ready == 1, "R2 after reset", {sel_n, req_ready}, 3);

    send(8'hA5, 8, 16'h003C, 0);          wait (outstanding == 0);
    send(8'h3C, 4, 16'h000A, 0);          wait (outstanding == 0); // R7 minimum
    send(8'h81, 16, 16'hBEEF, 0);         wait (outstanding == 0); // R7 maximum
    send(8'h7E, 0, 16'hFFF5, 0);          wait (outstanding == 0); // R7 clamp low
    send(8'h00, 31, 16'h1234, 0);         wait (outstanding == 0); // R7 clamp high
    send(8'hFF, 5, 16'hFFE2, 0);          wait (outstanding == 0); // R8 zero upper bits, R6 leading 0
    repeat (10) @(negedge clk);

    // back-to-back, R3 ordering and back-pressure, R9 gap
    send(8'h12, 6, 16'h0015, 0);
    send(8'h34, 9, 16'h0101, 1);
    @(negedge clk);
    chk(req_ready == 0, "R3 ready low while waiting", req_ready, 0);
    send(8'h56, 12, 16'h0ABC, 1);
    wait (outstanding == 0);
    repeat (20) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule